// File: doc/BRIEF.md
# Byte-Wide Link Port Packer

This block is one end of a point-to-point link that carries one byte per transfer. A direction input sets it up as a transmitter or as a receiver. As a transmitter it takes whole words from the core, holds up to two of them, and sends each one as a series of bytes, lowest byte first. Each byte goes out with a strobe, and the far end's acknowledge paces the series. As a receiver it collects strobed bytes into words. It holds up to two finished words for the core, and it lowers its own acknowledge when both slots are taken. A width input sets the word size to 32 bits (four bytes) or 48 bits (six bytes).

On the core side the block has a plain valid/ready word interface in each direction. Four status outputs report whether each word buffer is empty or full. The link runs in the same clock domain as the core. A strobe is sampled at each rising edge of `clk`, and so is the acknowledge.

If the direction or the width changes while a word is partly moved, that word is dropped, so the next word starts again at its lowest byte.

Top module: `linkport_packer`

## Requirements
- R1: While reset is applied, and until the first configuration change after it, with receive mode and 32-bit words selected: `tx_empty` and `rx_empty` are high, `tx_full`, `rx_full`, `rd_valid`, `wr_ready` and `lk_stb_o` are low, and `lk_ack_o` is high.
- R2: In transmit mode each buffered word leaves as bytes on `lk_dat_o`, starting at bits 7:0 and rising. A 32-bit word sends bits 31:0 as four bytes. A 48-bit word (`wide48`=1) sends all six bytes. Words leave in the order they were accepted.
- R3: `lk_stb_o` is high in the cycle after a rising edge at which all of these held: transmit mode was selected, no configuration change was under way, a word was buffered, and `lk_ack_i` was high. At every other time it is low. This gives at most one byte per cycle.
- R4: In receive mode the byte on `lk_dat_i` is taken at each edge where `lk_stb_i` is high. Bytes fill the word from bits 7:0 upward. A 32-bit word is complete after four bytes and carries zero in bits 47:32. A 48-bit word is complete after six bytes.
- R5: The receive side holds two complete words. In receive mode `lk_ack_o` is high exactly when fewer than two words are held and no configuration change is under way.
- R6: `wr_ready` is high only in transmit mode with fewer than two words held. A word is taken at an edge where `wr_valid` and `wr_ready` are both high. A write at any other time has no effect.
- R7: `tx_empty`/`tx_full` and `rx_empty`/`rx_full` show, for each side, whether zero or two words are held.
- R8: A cycle in which `dir_tx` or `wide48` differs from its value at the previous edge is a configuration change. During that cycle any partly sent or partly received word is dropped, link input is ignored and `lk_ack_o` is low. The next word then starts at its lowest byte.
- R9: In transmit mode `lk_ack_o` is low and `lk_stb_i` has no effect. In receive mode `lk_stb_o` stays low.
- R10: `rd_valid` is high while a received word is held, and `rd_data` shows the oldest word. That word is removed at an edge where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, `rd_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the core side and the link side |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_tx | input | 1 | 1 selects transmit, 0 selects receive |
| wide48 | input | 1 | 1 selects 48-bit words, 0 selects 32-bit words |
| wr_valid | input | 1 | Core offers a word for sending |
| wr_ready | output | 1 | Transmit buffer accepts a word |
| wr_data | input | 48 | Word to send |
| rd_valid | output | 1 | A received word is available |
| rd_ready | input | 1 | Core takes the received word |
| rd_data | output | 48 | Oldest received word |
| lk_stb_o | output | 1 | Outgoing byte strobe |
| lk_dat_o | output | 8 | Outgoing byte |
| lk_ack_i | input | 1 | Far end can take bytes |
| lk_stb_i | input | 1 | Incoming byte strobe |
| lk_dat_i | input | 8 | Incoming byte |
| lk_ack_o | output | 1 | This end can take bytes |
| tx_empty | output | 1 | Transmit buffer holds no word |
| tx_full | output | 1 | Transmit buffer holds two words |
| rx_empty | output | 1 | Receive buffer holds no word |
| rx_full | output | 1 | Receive buffer holds two words |

## Verification
The bench builds the block with its default parameters: 48-bit wide words, 32-bit narrow words and two buffer slots per side. Both word sizes are therefore chosen at run time through `wide48` on a single build. With only two slots, a sparse `rd_ready` or a sparse `lk_ack_i` fills a buffer within a few words. That brings acknowledge withdrawal, blocked writes and reads at a full buffer into reach many times in each random phase. The small slot count also makes a configuration change while the head word is half sent or half received easy to set up directly.

// File: rtl/lpk_pkg.sv
package lpk_pkg;

  // Link lane width: one byte moves per strobe.
  localparam int unsigned LPK_LANE_W = 8;

  typedef enum logic {
    LPK_RX = 1'b0,
    LPK_TX = 1'b1
  } lpk_dir_e;

  // Number of lane transfers that make up a word of the given width.
  function automatic int unsigned lpk_beats(input int unsigned word_w);
    return word_w / LPK_LANE_W;
  endfunction

endpackage

// File: rtl/lpk_wbuf.sv
module lpk_wbuf #(
  parameter int unsigned W     = 48,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [PW-1:0]      wptr_q, wptr_d;
  logic [PW-1:0]      rptr_q, rptr_d;
  logic [CW-1:0]      cnt_q,  cnt_d;
  logic [DEPTH*W-1:0] slots;

  // Next-state logic for pointers and occupancy.
  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push) begin
      wptr_d = (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
    end
    if (pop) begin
      rptr_d = (rptr_q == PTR_LAST) ? '0 : rptr_q + 1'b1;
    end
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // One word register per slot, each with its own load enable.
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic         load;
    logic [W-1:0] word_q;

    assign load = push && (wptr_q == PW'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (load) begin
        word_q <= din;
      end
    end

    assign slots[s*W +: W] = word_q;
  end

  assign head  = slots[int'(rptr_q)*W +: W];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_FULL);

  // R6
  wbuf_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop);

  // R10
  wbuf_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R7
  wbuf_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> !empty);

endmodule

// File: rtl/lpk_tx_unpack.sv
module lpk_tx_unpack #(
  parameter int unsigned WIDE_W   = 48,
  parameter int unsigned NARROW_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run,
  input  logic                          flush,
  input  logic                          wide,
  input  logic [WIDE_W-1:0]             word,
  input  logic                          word_ok,
  input  logic                          ack_i,
  output logic                          take,
  output logic                          stb_o,
  output logic [lpk_pkg::LPK_LANE_W-1:0] dat_o
);

  import lpk_pkg::*;

  localparam int unsigned NB_WIDE   = lpk_beats(WIDE_W);
  localparam int unsigned NB_NARROW = lpk_beats(NARROW_W);
  localparam int unsigned IDX_W     = $clog2(NB_WIDE);
  localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(NB_WIDE - 1);
  localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(NB_NARROW - 1);

  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [IDX_W-1:0]      last_idx;
  logic                  fire;
  logic                  at_last;
  logic                  stb_d;
  logic                  dat_en;
  logic [LPK_LANE_W-1:0] dat_d;

  assign last_idx = wide ? LAST_WIDE : LAST_NARROW;
  assign fire     = run && word_ok && ack_i;
  assign at_last  = (idx_q == last_idx);
  // Release the head word after its last byte, or drop it when a
  // configuration change catches it half sent.
  assign take     = (fire && at_last) || (flush && (idx_q != '0));

  always_comb begin
    idx_d  = idx_q;
    stb_d  = fire;
    dat_en = fire;
    dat_d  = word[int'(idx_q)*LPK_LANE_W +: LPK_LANE_W];
    if (flush) begin
      idx_d = '0;
    end else if (fire) begin
      idx_d = at_last ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      stb_o <= 1'b0;
    end else begin
      idx_q <= idx_d;
      stb_o <= stb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_o <= '0;
    end else if (dat_en) begin
      dat_o <= dat_d;
    end
  end

  // R3
  tx_stb_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |-> ($past(ack_i) && $past(run)));

  // R2
  tx_idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (idx_q <= last_idx));

endmodule

// File: rtl/lpk_rx_pack.sv
module lpk_rx_pack #(
  parameter int unsigned WIDE_W   = 48,
  parameter int unsigned NARROW_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           run,
  input  logic                           flush,
  input  logic                           wide,
  input  logic                           stb_i,
  input  logic [lpk_pkg::LPK_LANE_W-1:0] dat_i,
  output logic                           done,
  output logic [WIDE_W-1:0]              word
);

  import lpk_pkg::*;

  localparam int unsigned NB_WIDE   = lpk_beats(WIDE_W);
  localparam int unsigned NB_NARROW = lpk_beats(NARROW_W);
  localparam int unsigned IDX_W     = $clog2(NB_WIDE);
  localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(NB_WIDE - 1);
  localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(NB_NARROW - 1);

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [IDX_W-1:0]  last_idx;
  logic [WIDE_W-1:0] asm_q, asm_d;
  logic              accept;
  logic              at_last;

  assign last_idx = wide ? LAST_WIDE : LAST_NARROW;
  assign accept   = run && stb_i;
  assign at_last  = (idx_q == last_idx);
  assign done     = accept && at_last;
  assign word     = asm_d;

  // A fresh word starts from zero so narrow words carry a clear top.
  always_comb begin
    asm_d = (idx_q == '0) ? '0 : asm_q;
    asm_d[int'(idx_q)*LPK_LANE_W +: LPK_LANE_W] = dat_i;
    idx_d = idx_q;
    if (flush) begin
      idx_d = '0;
    end else if (accept) begin
      idx_d = at_last ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asm_q <= '0;
    end else if (accept) begin
      asm_q <= asm_d;
    end
  end

  if (WIDE_W > NARROW_W) begin : g_narrow_chk
    // R4
    rx_narrow_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !wide) |-> (word[WIDE_W-1:NARROW_W] == '0));
  end

  // R8
  rx_flush_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !accept) |=> !done);

endmodule

// File: rtl/linkport_packer.sv
module linkport_packer #(
  parameter int unsigned WIDE_W   = 48,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned DEPTH    = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           dir_tx,
  input  logic                           wide48,
  input  logic                           wr_valid,
  output logic                           wr_ready,
  input  logic [WIDE_W-1:0]              wr_data,
  output logic                           rd_valid,
  input  logic                           rd_ready,
  output logic [WIDE_W-1:0]              rd_data,
  output logic                           lk_stb_o,
  output logic [lpk_pkg::LPK_LANE_W-1:0] lk_dat_o,
  input  logic                           lk_ack_i,
  input  logic                           lk_stb_i,
  input  logic [lpk_pkg::LPK_LANE_W-1:0] lk_dat_i,
  output logic                           lk_ack_o,
  output logic                           tx_empty,
  output logic                           tx_full,
  output logic                           rx_empty,
  output logic                           rx_full
);

  import lpk_pkg::*;

  // Asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_ni = rst_sync_q[1];

  // Configuration tracking: a mismatch marks a change cycle.
  lpk_dir_e dir_now, dir_q;
  logic     wide_q;
  logic     cfg_chg;

  assign dir_now = lpk_dir_e'(dir_tx);
  assign cfg_chg = (dir_now != dir_q) || (wide48 != wide_q);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= LPK_RX;
      wide_q <= 1'b0;
    end else begin
      dir_q  <= dir_now;
      wide_q <= wide48;
    end
  end

  // Transmit path
  logic              tx_push;
  logic              tx_pop;
  logic [WIDE_W-1:0] tx_head;
  logic              tx_run;

  assign wr_ready = (dir_now == LPK_TX) && !tx_full;
  assign tx_push  = wr_valid && wr_ready;
  assign tx_run   = (dir_now == LPK_TX) && !cfg_chg;

  lpk_wbuf #(.W(WIDE_W), .DEPTH(DEPTH)) u_tx_buf (
    .clk   (clk),
    .rst_n (rst_ni),
    .push  (tx_push),
    .din   (wr_data),
    .pop   (tx_pop),
    .head  (tx_head),
    .empty (tx_empty),
    .full  (tx_full)
  );

  lpk_tx_unpack #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_tx_unpack (
    .clk     (clk),
    .rst_n   (rst_ni),
    .run     (tx_run),
    .flush   (cfg_chg),
    .wide    (wide48),
    .word    (tx_head),
    .word_ok (!tx_empty),
    .ack_i   (lk_ack_i),
    .take    (tx_pop),
    .stb_o   (lk_stb_o),
    .dat_o   (lk_dat_o)
  );

  // Receive path
  logic              rx_run;
  logic              rx_done;
  logic [WIDE_W-1:0] rx_word;
  logic              rx_pop;

  assign rx_run   = (dir_now == LPK_RX) && !cfg_chg;
  assign lk_ack_o = rx_run && !rx_full;
  assign rx_pop   = rd_valid && rd_ready;
  assign rd_valid = !rx_empty;

  lpk_rx_pack #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_rx_pack (
    .clk   (clk),
    .rst_n (rst_ni),
    .run   (rx_run),
    .flush (cfg_chg),
    .wide  (wide48),
    .stb_i (lk_stb_i),
    .dat_i (lk_dat_i),
    .done  (rx_done),
    .word  (rx_word)
  );

  lpk_wbuf #(.W(WIDE_W), .DEPTH(DEPTH)) u_rx_buf (
    .clk   (clk),
    .rst_n (rst_ni),
    .push  (rx_done),
    .din   (rx_word),
    .pop   (rx_pop),
    .head  (rd_data),
    .empty (rx_empty),
    .full  (rx_full)
  );

  // R9
  rx_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !$past(dir_tx) |-> !lk_stb_o);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R5
  ack_full_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (rx_full && !rd_ready) |=> !lk_ack_o);

  // R9
  tx_mode_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    dir_tx |-> !lk_ack_o);

endmodule

// File: tb/linkport_packer_bench.sv
`timescale 1ns/1ps
module linkport_packer_bench;

  localparam int WW = 48;
  localparam int DP = 2;

  logic          clk;
  logic          rst_n;
  logic          dir_tx, wide48;
  logic          wr_valid, wr_ready;
  logic [WW-1:0] wr_data, rd_data;
  logic          rd_valid, rd_ready;
  logic          lk_stb_o, lk_ack_i, lk_stb_i, lk_ack_o;
  logic [7:0]    lk_dat_o, lk_dat_i;
  logic          tx_empty, tx_full, rx_empty, rx_full;

  int checks;
  int errors;
  int cyc_n;

  linkport_packer u_linkport_packer (
    .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .wide48(wide48),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .lk_stb_o(lk_stb_o), .lk_dat_o(lk_dat_o), .lk_ack_i(lk_ack_i),
    .lk_stb_i(lk_stb_i), .lk_dat_i(lk_dat_i), .lk_ack_o(lk_ack_o),
    .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc_n <= cyc_n + 1;
    if (cyc_n > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 150000", cyc_n);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int beats(input bit wide);
    return wide ? 6 : 4;
  endfunction

  // Random transmit traffic against a randomly stalling far end.
  task automatic run_tx(input bit wide, input int n_cycles);
    logic [7:0]    txq[$];
    logic [7:0]    exp_b;
    logic [WW-1:0] pword;
    bit            did_push, prev_ack, draining;
    int            tcnt, bcnt, nb, hold;
    nb = beats(wide);
    dir_tx = 1'b1; wide48 = wide; wr_valid = 1'b0; lk_ack_i = 1'b0;
    lk_stb_i = 1'b0; rd_ready = 1'b0;
    @(negedge clk);
    did_push = 0; prev_ack = 0; tcnt = 0; bcnt = 0; hold = 0; pword = '0;
    for (int c = 0; c < n_cycles + 2000; c++) begin
      draining = (c >= n_cycles);
      if (did_push) begin
        for (int b = 0; b < nb; b++) txq.push_back(pword[8*b +: 8]);
        tcnt++;
      end
      // R3: strobe exactly when ack was high and a word was held
      chk(lk_stb_o == (prev_ack && hold > 0), "R3 tx strobe pacing", 64'(lk_stb_o), 64'(prev_ack && hold > 0));
      if (lk_stb_o) begin
        if (txq.size() == 0) begin
          chk(1'b0, "R2 unexpected tx byte", 64'(lk_dat_o), 64'h0);
        end else begin
          exp_b = txq.pop_front();
          chk(lk_dat_o == exp_b, "R2 tx byte order", 64'(lk_dat_o), 64'(exp_b));
        end
        bcnt++;
        if (bcnt == nb) begin bcnt = 0; tcnt--; end
      end
      chk(tx_full == (tcnt == DP), "R7 tx_full", 64'(tx_full), 64'(tcnt == DP));
      chk(tx_empty == (tcnt == 0), "R7 tx_empty", 64'(tx_empty), 64'(tcnt == 0));
      chk(wr_ready == (tcnt < DP), "R6 wr_ready", 64'(wr_ready), 64'(tcnt < DP));
      chk(lk_ack_o == 1'b0, "R9 ack low in transmit", 64'(lk_ack_o), 64'h0);
      chk(rx_empty == 1'b1, "R9 strobes ignored in transmit", 64'(rx_empty), 64'h1);
      wr_valid = !draining && ($urandom % 3 != 0);
      wr_data  = WW'({$urandom(), $urandom()});
      did_push = wr_valid && wr_ready;
      pword    = wr_data;
      lk_ack_i = draining ? 1'b1 : ($urandom % 4 != 0);
      prev_ack = lk_ack_i;
      hold     = tcnt;
      lk_stb_i = $urandom % 2;
      lk_dat_i = 8'($urandom);
      if (draining && tcnt == 0 && !did_push) break;
      @(negedge clk);
    end
    wr_valid = 1'b0; lk_stb_i = 1'b0; lk_ack_i = 1'b0;
    chk(txq.size() == 0, "R2 all tx bytes delivered", 64'(txq.size()), 64'h0);
  endtask

  // Random receive traffic with a slow reader.
  task automatic run_rx(input bit wide, input int n_cycles);
    logic [WW-1:0] rxq[$];
    logic [WW-1:0] asm_w, hold_d;
    logic [7:0]    sbyte;
    bit            did_send, did_read, hold_v, draining;
    int            rbc, nb;
    nb = beats(wide);
    dir_tx = 1'b0; wide48 = wide; lk_stb_i = 1'b0; rd_ready = 1'b0;
    wr_valid = 1'b1; lk_ack_i = 1'b0;
    @(negedge clk);
    did_send = 0; did_read = 0; hold_v = 0; rbc = 0; asm_w = '0; sbyte = '0; hold_d = '0;
    for (int c = 0; c < n_cycles + 2000; c++) begin
      draining = (c >= n_cycles);
      if (did_send) begin
        asm_w[8*rbc +: 8] = sbyte;
        rbc++;
        if (rbc == nb) begin rxq.push_back(asm_w); asm_w = '0; rbc = 0; end
      end
      if (did_read) void'(rxq.pop_front());
      if (hold_v) chk(rd_valid && rd_data == hold_d, "R10 rd_data held", rd_data, hold_d);
      chk(rd_valid == (rxq.size() > 0), "R10 rd_valid", 64'(rd_valid), 64'(rxq.size() > 0));
      if (rd_valid && rxq.size() > 0)
        chk(rd_data == rxq[0], "R4 rx word packing", rd_data, rxq[0]);
      chk(rx_full == (rxq.size() == DP), "R7 rx_full", 64'(rx_full), 64'(rxq.size() == DP));
      chk(rx_empty == (rxq.size() == 0), "R7 rx_empty", 64'(rx_empty), 64'(rxq.size() == 0));
      chk(lk_ack_o == (rxq.size() < DP), "R5 ack vs buffer", 64'(lk_ack_o), 64'(rxq.size() < DP));
      chk(lk_stb_o == 1'b0, "R9 no strobe in receive", 64'(lk_stb_o), 64'h0);
      chk(wr_ready == 1'b0 && tx_empty, "R6 writes ignored in receive", 64'(wr_ready), 64'h0);
      sbyte    = 8'($urandom);
      lk_dat_i = sbyte;
      lk_stb_i = lk_ack_o && (!draining || rbc != 0) && ($urandom % 3 != 0);
      did_send = lk_stb_i;
      rd_ready = draining ? 1'b1 : ($urandom % 4 == 0);
      did_read = rd_valid && rd_ready;
      hold_v   = rd_valid && !rd_ready;
      hold_d   = rd_data;
      lk_ack_i = $urandom % 2;
      if (draining && rbc == 0 && !lk_stb_i && rxq.size() == 0) break;
      @(negedge clk);
    end
    lk_stb_i = 1'b0; rd_ready = 1'b0; wr_valid = 1'b0;
  endtask

  // R8: receive side drops a partial word on a direction change.
  task automatic r8_rx;
    dir_tx = 1'b0; wide48 = 1'b0; lk_stb_i = 1'b0; rd_ready = 1'b0; wr_valid = 1'b0; lk_ack_i = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      lk_stb_i = 1'b1; lk_dat_i = 8'hA0 + 8'(i);
      @(negedge clk);
    end
    lk_stb_i = 1'b0;
    dir_tx = 1'b1;
    @(negedge clk);
    chk(lk_ack_o == 1'b0, "R8 ack low on change", 64'(lk_ack_o), 64'h0);
    repeat (2) @(negedge clk);
    dir_tx = 1'b0;
    lk_stb_i = 1'b1; lk_dat_i = 8'h5A;
    chk(lk_ack_o == 1'b0, "R8 ack low on change back", 64'(lk_ack_o), 64'h0);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      lk_stb_i = 1'b1; lk_dat_i = 8'h11 * 8'(i + 1);
      @(negedge clk);
    end
    lk_stb_i = 1'b0;
    chk(rd_valid && rd_data == 48'h0000_4433_2211, "R8 rx restarts at byte 0", rd_data, 48'h0000_4433_2211);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    chk(rx_empty == 1'b1, "R8 rx one word only", 64'(rx_empty), 64'h1);
  endtask

  // R8: transmit side drops a half-sent word on a direction change.
  task automatic r8_tx;
    logic [47:0] wb;
    dir_tx = 1'b1; wide48 = 1'b0; lk_ack_i = 1'b0; lk_stb_i = 1'b0;
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 48'h0000_D4C3_B2A1;
    @(negedge clk);
    wr_valid = 1'b0; lk_ack_i = 1'b1;
    @(negedge clk);
    chk(lk_stb_o && lk_dat_o == 8'hA1, "R2 first byte low", 64'(lk_dat_o), 64'hA1);
    @(negedge clk);
    chk(lk_stb_o && lk_dat_o == 8'hB2, "R2 second byte", 64'(lk_dat_o), 64'hB2);
    lk_ack_i = 1'b0; dir_tx = 1'b0;
    @(negedge clk);
    chk(tx_empty == 1'b1, "R8 partial tx word dropped", 64'(tx_empty), 64'h1);
    chk(lk_stb_o == 1'b0, "R3 no strobe without ack", 64'(lk_stb_o), 64'h0);
    repeat (2) @(negedge clk);
    dir_tx = 1'b1;
    @(negedge clk);
    wb = 48'h0000_8877_6655;
    wr_valid = 1'b1; wr_data = wb;
    @(negedge clk);
    wr_valid = 1'b0; lk_ack_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(lk_stb_o && lk_dat_o == wb[8*i +: 8], "R8 tx restarts at byte 0", 64'(lk_dat_o), 64'(wb[8*i +: 8]));
    end
    lk_ack_i = 1'b0;
    @(negedge clk);
    chk(tx_empty && !lk_stb_o, "R2 word ends after four bytes", 64'(lk_stb_o), 64'h0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    checks = 0; errors = 0; cyc_n = 0;
    rst_n = 1'b0; dir_tx = 1'b0; wide48 = 1'b0; wr_valid = 1'b0; wr_data = '0;
    rd_ready = 1'b0; lk_ack_i = 1'b0; lk_stb_i = 1'b0; lk_dat_i = '0;
    repeat (3) @(negedge clk);
    chk(tx_empty && rx_empty && !tx_full && !rx_full, "R1 buffers empty in reset", {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_empty && rx_empty && !tx_full && !rx_full, "R1 status after reset", {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
    chk(!rd_valid && !wr_ready && !lk_stb_o, "R1 handshakes idle", {rd_valid, wr_ready, lk_stb_o}, 3'b000);
    chk(lk_ack_o == 1'b1, "R1 ack high in receive", 64'(lk_ack_o), 64'h1);

    run_tx(1'b0, 600);
    run_tx(1'b1, 600);
    run_rx(1'b0, 600);
    run_rx(1'b1, 600);
    r8_rx();
    r8_tx();
    run_tx(1'b1, 300);
    run_rx(1'b0, 300);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule